// File: doc/BRIEF.md
# Handshake-Gated Serial Word Tester

This block receives a response word that a unit under test shifts in serially. The unit under test sees a ready line that this block holds high at all times. The receiver accepts clock pulses only while the unit under test's mode line and proceed line are both high. Sixteen rising clock edges, most significant bit first, fill a serial-to-parallel register. The completed word then goes to a register of octal digits, so that an operator can read the response code by eye. A display-inhibit input freezes those digits.

The block also contains a small transmitter for self-test. While the active-low force input is low, a start pulse sends a test word on a transmit clock and a transmit data line. The transmit clock is inverted through an XNOR stage, so it idles high, falls as each bit is launched and rises in the middle of the bit. For loopback, the transmit clock and data are wired to the receive clock and data, ready is wired to proceed, and mode is held high. The same block then receives its own test word with correct phasing. All input lines are brought into the system clock domain through flop synchronisers.

Top module: `serial_word_tester`

## Requirements
- R1: `ready_o` is 1 during and after reset, at all times.
- R2: A rising edge on `sclk_i` is ignored unless `mode_i` and `proceed_i` are both high. Edges sent with only one of them high produce no `word_valid_o` and leave `octal_o` unchanged.
- R3: While the gate is open, `sdata_i` is sampled on each rising edge of `sclk_i`, most significant bit first. The 16th edge completes the word.
- R4: `word_valid_o` is a pulse one system clock wide. It is first seen high after the 4th rising edge of `clk` that follows the 16th rising edge on `sclk_i` (with SYNC_STAGES = 2).
- R5: Digit k of `octal_o` (bits 3k+2..3k, k = 0..4) equals bits 3k+2..3k of the word. Digit 5 (bits 17..15) is {0, 0, word bit 15}.
- R6: While `disp_inhibit_i` is high, `octal_o` holds its last value, and `word_valid_o` still pulses for a completed word.
- R7: A low gate (mode AND proceed) resets the bit count, so a partly received word is discarded.
- R8: While `force_n_i` is high, `tx_clk_o` and `tx_data_o` are held at 0 and `tx_start_i` is ignored.
- R9: While `force_n_i` is low, `tx_clk_o` idles high. A start pulse sends `tx_word_i` MSB first on `tx_data_o`, and each bit has a rising `tx_clk_o` edge in its middle. Looping the transmit lines back returns the same word on `octal_o`.
- R10: Fewer than 16 gated edges produce no `word_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Mode handshake line from the unit under test |
| proceed_i | input | 1 | Proceed handshake line from the unit under test |
| sclk_i | input | 1 | Serial receive clock, asynchronous |
| sdata_i | input | 1 | Serial receive data, asynchronous |
| disp_inhibit_i | input | 1 | High freezes the octal display register |
| force_n_i | input | 1 | Low enables the transmitter and inverts its clock |
| tx_start_i | input | 1 | Starts transmission of the test word |
| tx_word_i | input | 16 | Outgoing test word |
| ready_o | output | 1 | Constant-high ready line |
| tx_clk_o | output | 1 | Transmit clock |
| tx_data_o | output | 1 | Transmit data |
| word_valid_o | output | 1 | One-cycle pulse when a word completes |
| octal_o | output | 18 | Six octal digits of the last word |

## Verification
A rising edge on the serial clock passes two synchroniser flops and one edge-detect flop, so the shift register changes on the third system clock edge. The word-valid pulse and the new display digits appear on the fourth edge. One check launches the final edge between system clock edges and counts falling edges of `clk` until the pulse is seen: it must be exactly four, and the pulse must be low on the fifth. Every other check waits a fixed margin longer than this path before it reads the counters and digits. In loopback, a transmitted word takes 16 × 8 system cycles plus the receive latency, and the bench polls for the pulse within a bounded window.

// File: rtl/swt_pkg.sv
package swt_pkg;
  // Number of octal digits needed to show a word of the given width.
  function automatic int octal_digits(input int width);
    return (width + 2) / 3;
  endfunction
endpackage

// File: rtl/swt_sync.sv
module swt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/swt_rx.sv
module swt_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate,
  input  logic              sclk,
  input  logic              sdata,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  localparam int CW = $clog2(WORD_W);

  logic              sclk_prev;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] sh;
  logic              rise;
  logic              last;
  logic [WORD_W-1:0] next_sh;

  assign rise = gate && sclk && !sclk_prev;
  assign last = (cnt == CW'(WORD_W - 1));

  // The first bit of a transaction clears the register before shifting.
  always_comb begin
    if (cnt == '0) next_sh = {{(WORD_W-1){1'b0}}, sdata};
    else           next_sh = {sh[WORD_W-2:0], sdata};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      done      <= 1'b0;
      word      <= '0;
    end else begin
      sclk_prev <= sclk;
      done      <= 1'b0;
      if (!gate) begin
        cnt <= '0;
      end else if (rise) begin
        sh <= next_sh;
        if (last) begin
          cnt  <= '0;
          done <= 1'b1;
          word <= next_sh;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/swt_octal.sv
module swt_octal #(
  parameter int WORD_W = 16,
  parameter int NDIG   = swt_pkg::octal_digits(WORD_W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  done,
  input  logic [WORD_W-1:0]     word,
  input  logic                  inhibit,
  output logic                  valid,
  output logic [NDIG*3-1:0]     octal
);
  logic [NDIG*3-1:0]      padded;
  logic [NDIG-1:0][2:0]   digit;

  always_comb begin
    padded = '0;
    padded[WORD_W-1:0] = word;
  end

  for (genvar k = 0; k < NDIG; k++) begin : g_digit
    assign digit[k] = padded[3*k +: 3];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      octal <= '0;
    end else begin
      valid <= done;
      if (done && !inhibit) octal <= digit;
    end
  end
endmodule

// File: rtl/swt_tx.sv
module swt_tx #(
  parameter int WORD_W = 16,
  parameter int HALF   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              force_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              tx_clk,
  output logic              tx_data
);
  localparam int PW = $clog2(2 * HALF);
  localparam int BW = $clog2(WORD_W);

  logic              en;
  logic              busy;
  logic [PW-1:0]     ph;
  logic [BW-1:0]     bi;
  logic [WORD_W-1:0] sh;
  logic              raw;

  assign en  = !force_n;
  assign raw = busy && (ph < PW'(HALF));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      ph      <= '0;
      bi      <= '0;
      sh      <= '0;
      tx_clk  <= 1'b0;
      tx_data <= 1'b0;
    end else begin
      if (!en) begin
        busy <= 1'b0;
      end else if (!busy && start) begin
        busy <= 1'b1;
        sh   <= word;
        ph   <= '0;
        bi   <= '0;
      end else if (busy) begin
        if (ph == PW'(2 * HALF - 1)) begin
          ph <= '0;
          if (bi == BW'(WORD_W - 1)) begin
            busy <= 1'b0;
          end else begin
            bi <= bi + 1'b1;
            sh <= {sh[WORD_W-2:0], 1'b0};
          end
        end else begin
          ph <= ph + 1'b1;
        end
      end
      // XNOR with the low force line inverts the raw clock.
      tx_clk  <= en && !(raw ^ force_n);
      tx_data <= en && busy && sh[WORD_W-1];
    end
  end
endmodule

// File: rtl/serial_word_tester.sv
module serial_word_tester #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int TX_HALF     = 4
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         mode_i,
  input  logic                                         proceed_i,
  input  logic                                         sclk_i,
  input  logic                                         sdata_i,
  input  logic                                         disp_inhibit_i,
  input  logic                                         force_n_i,
  input  logic                                         tx_start_i,
  input  logic [WORD_W-1:0]                            tx_word_i,
  output logic                                         ready_o,
  output logic                                         tx_clk_o,
  output logic                                         tx_data_o,
  output logic                                         word_valid_o,
  output logic [3*swt_pkg::octal_digits(WORD_W)-1:0]   octal_o
);
  localparam int NDIG  = swt_pkg::octal_digits(WORD_W);
  localparam int OCT_W = 3 * NDIG;

  logic [2:0]        raw_in;
  logic [2:0]        sync_in;
  logic              rx_done;
  logic [WORD_W-1:0] rx_word;

  assign ready_o = 1'b1;
  assign raw_in  = {mode_i && proceed_i, sclk_i, sdata_i};

  swt_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_in)
  );

  swt_rx #(.WORD_W(WORD_W)) u_rx (
    .clk   (clk),
    .rst   (rst),
    .gate  (sync_in[2]),
    .sclk  (sync_in[1]),
    .sdata (sync_in[0]),
    .done  (rx_done),
    .word  (rx_word)
  );

  swt_octal #(.WORD_W(WORD_W), .NDIG(NDIG)) u_oct (
    .clk     (clk),
    .rst     (rst),
    .done    (rx_done),
    .word    (rx_word),
    .inhibit (disp_inhibit_i),
    .valid   (word_valid_o),
    .octal   (octal_o)
  );

  swt_tx #(.WORD_W(WORD_W), .HALF(TX_HALF)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .force_n (force_n_i),
    .start   (tx_start_i),
    .word    (tx_word_i),
    .tx_clk  (tx_clk_o),
    .tx_data (tx_data_o)
  );
endmodule

// File: rtl/swt_checker.sv
module swt_checker #(
  parameter int OCT_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             ready_o,
  input logic             word_valid_o,
  input logic             disp_inhibit_i,
  input logic             force_n_i,
  input logic             tx_clk_o,
  input logic             tx_data_o,
  input logic [OCT_W-1:0] octal_o
);
  always @(posedge clk) begin
    assert_ready_high_R1: assert (ready_o == 1'b1);
  end

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o);

  assert_display_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(disp_inhibit_i)) |-> $stable(octal_o));

  assert_tx_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    $past(force_n_i) |-> (!tx_clk_o && !tx_data_o));
endmodule

bind serial_word_tester swt_checker #(.OCT_W(OCT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .ready_o        (ready_o),
  .word_valid_o   (word_valid_o),
  .disp_inhibit_i (disp_inhibit_i),
  .force_n_i      (force_n_i),
  .tx_clk_o       (tx_clk_o),
  .tx_data_o      (tx_data_o),
  .octal_o        (octal_o)
);

// File: tb/serial_word_tester_tb.sv
module serial_word_tester_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_d = 1'b0, proceed_d = 1'b0, sclk_d = 1'b0, sdata_d = 1'b0;
  logic        loop = 1'b0;
  logic        disp_inhibit_i = 1'b0, force_n_i = 1'b1, tx_start_i = 1'b0;
  logic [15:0] tx_word_i = '0;
  logic        mode_i, proceed_i, sclk_i, sdata_i;
  logic        ready_o, tx_clk_o, tx_data_o, word_valid_o;
  logic [17:0] octal_o;

  int checks = 0;
  int fails = 0;
  int vcount = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign mode_i    = mode_d;
  assign proceed_i = loop ? ready_o   : proceed_d;
  assign sclk_i    = loop ? tx_clk_o  : sclk_d;
  assign sdata_i   = loop ? tx_data_o : sdata_d;

  serial_word_tester u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .proceed_i(proceed_i),
    .sclk_i(sclk_i), .sdata_i(sdata_i), .disp_inhibit_i(disp_inhibit_i),
    .force_n_i(force_n_i), .tx_start_i(tx_start_i), .tx_word_i(tx_word_i),
    .ready_o(ready_o), .tx_clk_o(tx_clk_o), .tx_data_o(tx_data_o),
    .word_valid_o(word_valid_o), .octal_o(octal_o)
  );

  always @(negedge clk) if (word_valid_o) vcount++;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_oct(input logic [15:0] w);
    logic [17:0] r = '0;
    for (int k = 0; k < 6; k++) r[3*k +: 3] = 3'((int'(w) >> (3*k)) % 8);
    return r;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdata_d = b;
    wait_n(3); sclk_d = 1'b1;
    wait_n(4); sclk_d = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    for (int i = 15; i > 15 - n; i--) send_bit(w[i]);
  endtask

  task automatic rx_word_check(input logic [15:0] w, input string req);
    int v0 = vcount;
    send_bits(w, 16);
    wait_n(8);
    check(vcount == v0 + 1, req, vcount - v0, 1);
    check(octal_o == exp_oct(w), req, octal_o, exp_oct(w));
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] keep;
    int v0;
    int seen;
    wait_n(5);
    check(ready_o == 1'b1, "R1 ready in reset", ready_o, 1);
    @(negedge clk); rst = 1'b0;
    wait_n(2);
    check(ready_o == 1'b1, "R1 ready after reset", ready_o, 1);
    check(word_valid_o == 1'b0 && octal_o == '0, "reset state octal", octal_o, 0);
    check(tx_clk_o == 1'b0 && tx_data_o == 1'b0, "R8 reset tx lines", {tx_clk_o, tx_data_o}, 0);

    // R2: half-open gate
    mode_d = 1'b1; proceed_d = 1'b0; wait_n(4);
    v0 = vcount; send_bits(16'hFFFF, 16); wait_n(8);
    check(vcount == v0 && octal_o == '0, "R2 mode only", octal_o, 0);
    mode_d = 1'b0; proceed_d = 1'b1; wait_n(4);
    send_bits(16'hFFFF, 16); wait_n(8);
    check(vcount == v0 && octal_o == '0, "R2 proceed only", octal_o, 0);

    // R3/R5 sweep
    mode_d = 1'b1; wait_n(4);
    rx_word_check(16'h0000, "R3 zero");
    rx_word_check(16'hFFFF, "R5 ones");
    rx_word_check(16'h8000, "R5 top digit");
    rx_word_check(16'h0001, "R3 lsb");
    rx_word_check(16'hA5A5, "R3 pattern");
    check(octal_o[17:16] == 2'b00, "R5 pad bits", octal_o[17:16], 0);
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rx_word_check(lfsr, "R5 sweep");
    end

    // R10 then R7
    keep = octal_o[15:0];
    v0 = vcount; send_bits(16'h1234, 10); wait_n(10);
    check(vcount == v0, "R10 short word", vcount - v0, 0);
    mode_d = 1'b0; wait_n(10); mode_d = 1'b1; wait_n(10);
    rx_word_check(16'h5A3C, "R7 gate drop restart");

    // R4 latency and width
    send_bits(16'hC3C3, 15);
    @(negedge clk); sdata_d = 1'b1; wait_n(3);
    v0 = vcount; sclk_d = 1'b1; seen = 0;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      if (word_valid_o && seen == 0) seen = n;
      if (n == 5) check(word_valid_o == 1'b0, "R4 pulse width", word_valid_o, 0);
    end
    check(seen == 4, "R4 latency", seen, 4);
    sclk_d = 1'b0; wait_n(4);
    check(octal_o == exp_oct(16'hC3C3), "R4 word", octal_o, exp_oct(16'hC3C3));

    // R6 display hold
    disp_inhibit_i = 1'b1; wait_n(2);
    v0 = vcount; send_bits(16'h7E81, 16); wait_n(8);
    check(vcount == v0 + 1, "R6 valid while held", vcount - v0, 1);
    check(octal_o == exp_oct(16'hC3C3), "R6 held", octal_o, exp_oct(16'hC3C3));
    disp_inhibit_i = 1'b0; wait_n(2);
    rx_word_check(16'h0F0F, "R6 released");

    // R8 transmitter disabled
    mode_d = 1'b0; tx_word_i = 16'hFFFF;
    @(negedge clk); tx_start_i = 1'b1; @(negedge clk); tx_start_i = 1'b0;
    seen = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk); if (tx_clk_o || tx_data_o) seen++;
    end
    check(seen == 0, "R8 tx quiet", seen, 0);

    // R9 loopback
    force_n_i = 1'b0; loop = 1'b1; wait_n(6);
    check(tx_clk_o == 1'b1, "R9 idle high", tx_clk_o, 1);
    mode_d = 1'b1; wait_n(6);
    for (int t = 0; t < 3; t++) begin
      case (t)
        0: tx_word_i = 16'hB00B;
        1: tx_word_i = 16'h8001;
        default: tx_word_i = 16'h6DB6;
      endcase
      v0 = vcount;
      @(negedge clk); tx_start_i = 1'b1; @(negedge clk); tx_start_i = 1'b0;
      for (int n = 0; n < 400 && vcount == v0; n++) @(negedge clk);
      wait_n(4);
      check(vcount == v0 + 1, "R9 loop valid", vcount - v0, 1);
      check(octal_o == exp_oct(tx_word_i), "R9 loop word", octal_o, exp_oct(tx_word_i));
    end
    mode_d = 1'b0; wait_n(4); loop = 1'b0; force_n_i = 1'b1;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule